// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital side of a two-channel 16-bit converter as a parallel host sees it. Each channel has two register stages. The first stage is a staging register that the host fills over the bus. The second stage is the output register, whose value drives the converter code outputs. The host can fill either staging register at any time without changing the outputs. A separate load strobe then moves both staging values into the output registers in the same clock cycle. The host can also read either staging register back over the bus.

The host pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and every action is taken on an edge of the synchronized signal, never on a level. A write takes effect when chip select rises. The data is the bus value sampled while chip select was low. A rising edge on the clear strobe forces all four registers to a reset code chosen by a parameter: mid-scale 0x8000 by default, or zero-scale 0x0000 in the other variant. A clear edge overrides every other input. Software cannot access the output registers directly.

Top module: `dac_pair_frontend`

## Requirements
- R1: After the system reset, both code outputs equal RESET_CODE, bus_oe is low, and a readback of either staging register returns RESET_CODE.
- R2: A write is cs_n low with rd_wr low (0 = write). When chip select rises, the data sampled during the low phase goes into the staging register chosen by chan_sel (0 = channel A, 1 = channel B). The other staging register and both code outputs keep their values.
- R3: A read is cs_n low with rd_wr high (1 = read). It raises bus_oe, and bus_out shows the staging register chosen by chan_sel, including values that have not yet been loaded.
- R4: bus_oe is low while cs_n is high, and it is also low during a write.
- R5: A rising edge of load_strobe while cs_n is high copies both staging registers into both output registers in the same cycle.
- R6: A rising edge of load_strobe while cs_n is low has no effect. If cs_n then rises while load_strobe stays high, there is still no load.
- R7: A load is triggered by the edge, not the level. While load_strobe stays high, later writes change the staging registers but not the code outputs.
- R8: A rising edge of clr_strobe sets both staging registers and both output registers to RESET_CODE, whatever the other inputs are doing.
- R9: When the clear and load edges are detected in the same cycle, the clear wins.
- R10: Every strobe reaches the registers on the third clock edge after it changes, so a code output only changes three edges after a load or clear edge at the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write; has effect only while cs_n is low |
| chan_sel | input | 1 | 0 = channel A, 1 = channel B |
| load_strobe | input | 1 | Rising edge copies staging registers to output registers |
| clr_strobe | input | 1 | Rising edge sets all registers to RESET_CODE |
| bus_in | input | W | Data driven by the host |
| bus_out | output | W | Readback data; zero when not enabled |
| bus_oe | output | 1 | Drive enable for the bus; low means high impedance |
| code_a | output | W | Channel A output register |
| code_b | output | W | Channel B output register |

## Verification
Random sequences of writes, reads and loads on both channels are compared against a two-stage model of the registers. These sequences show whether a write goes to the wrong channel and whether it leaks into the outputs before a load. Directed cases cover the difference between edge and level triggering: a load raised while chip select is low, a load held high across later writes, and clear and load raised together. A second instance built with the zero-scale parameter checks that the reset code follows the variant.

// File: rtl/dac_pair_frontend.sv
module dac_pair_frontend #(
  parameter int W = 16,
  parameter int SYNC = 2,
  parameter int unsigned RESET_CODE = 32'h8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_wr,
  input  logic         chan_sel,
  input  logic         load_strobe,
  input  logic         clr_strobe,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b
);
  localparam logic [W-1:0] RST_VAL = W'(RESET_CODE);
  localparam logic [4:0] IDLE = 5'b00001;

  logic [4:0] stg [SYNC];
  logic [4:0] ctl, ctl_d;
  logic cs_s, rw_s, sel_s, ld_rise, clr_rise, cs_rise;
  logic [W-1:0] cap_data;
  logic cap_sel, cap_wr;
  logic [W-1:0] in_reg [2];
  logic [W-1:0] dac_reg [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) stg[i] <= IDLE;
      ctl_d <= IDLE;
    end else begin
      stg[0] <= {clr_strobe, load_strobe, chan_sel, rd_wr, cs_n};
      for (int i = 1; i < SYNC; i++) stg[i] <= stg[i-1];
      ctl_d <= ctl;
    end

  assign ctl      = stg[SYNC-1];
  assign cs_s     = ctl[0];
  assign rw_s     = ctl[1];
  assign sel_s    = ctl[2];
  assign ld_rise  = ctl[3] & ~ctl_d[3];
  assign clr_rise = ctl[4] & ~ctl_d[4];
  assign cs_rise  = ctl[0] & ~ctl_d[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_data <= '0;
      cap_sel  <= 1'b0;
      cap_wr   <= 1'b0;
    end else if (!cs_s) begin
      cap_data <= bus_in;
      cap_sel  <= sel_s;
      cap_wr   <= ~rw_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        in_reg[c]  <= RST_VAL;
        dac_reg[c] <= RST_VAL;
      end
    end else if (clr_rise) begin
      for (int c = 0; c < 2; c++) begin
        in_reg[c]  <= RST_VAL;
        dac_reg[c] <= RST_VAL;
      end
    end else begin
      if (cs_rise && cap_wr) in_reg[cap_sel] <= cap_data;
      if (ld_rise && cs_s)
        for (int c = 0; c < 2; c++) dac_reg[c] <= in_reg[c];
    end

  assign bus_oe  = ~cs_s & rw_s;
  assign bus_out = bus_oe ? in_reg[sel_s] : '0;
  assign code_a  = dac_reg[0];
  assign code_b  = dac_reg[1];
endmodule

module dac_pair_frontend_chk #(
  parameter int W = 16,
  parameter int unsigned RESET_CODE = 32'h8000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_wr,
  input logic         chan_sel,
  input logic         load_strobe,
  input logic         clr_strobe,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic [W-1:0] code_a,
  input logic [W-1:0] code_b
);
  // R4
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> !bus_oe);

  // R3
  read_only_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(rd_wr, 2));

  // R5
  code_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_a) |-> ($past(load_strobe, 3) || $past(clr_strobe, 3)));

  // R10
  code_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_b) |-> ($past(load_strobe, 3) || $past(clr_strobe, 3)));

  // R8
  clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_strobe, 3) && !$past(clr_strobe, 4)) |->
      (code_a == W'(RESET_CODE) && code_b == W'(RESET_CODE)));
endmodule

bind dac_pair_frontend dac_pair_frontend_chk #(.W(W), .RESET_CODE(RESET_CODE)) u_chk (.*);

// File: tb/dac_pair_frontend_bench.sv
module dac_pair_frontend_bench;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_wr = 1'b1, chan_sel = 1'b0;
  logic load_strobe = 1'b0, clr_strobe = 1'b0;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] bus_out, code_a, code_b, bus_out_z, code_a_z, code_b_z;
  logic bus_oe, bus_oe_z;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [W-1:0] m_in [2];
  logic [W-1:0] m_dac [2];

  always #10 clk = ~clk;

  dac_pair_frontend u_dac_pair_frontend (
    .clk, .rst_n, .cs_n, .rd_wr, .chan_sel, .load_strobe, .clr_strobe,
    .bus_in, .bus_out, .bus_oe, .code_a, .code_b);

  dac_pair_frontend #(.RESET_CODE(0)) u_zero (
    .clk, .rst_n, .cs_n, .rd_wr, .chan_sel, .load_strobe, .clr_strobe,
    .bus_in, .bus_out(bus_out_z), .bus_oe(bus_oe_z),
    .code_a(code_a_z), .code_b(code_b_z));

  function automatic logic [W-1:0] exp_read(input logic ch);
    return m_in[ch];
  endfunction

  function automatic logic [W-1:0] exp_code(input logic ch);
    return m_dac[ch];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic ch, input logic [W-1:0] d);
    chan_sel = ch; rd_wr = 1'b0; bus_in = d;
    tick(1);
    cs_n = 1'b0;
    tick(4);
    check("R4", bus_oe, 1'b0);
    cs_n = 1'b1;
    tick(4);
    bus_in = W'($urandom);
    rd_wr = 1'b1;
    m_in[ch] = d;
  endtask

  task automatic do_read(input logic ch, input string req);
    chan_sel = ch; rd_wr = 1'b1;
    tick(1);
    cs_n = 1'b0;
    tick(4);
    check(req, bus_oe, 1'b1);
    check(req, bus_out, exp_read(ch));
    cs_n = 1'b1;
    tick(4);
    check("R4", bus_oe, 1'b0);
  endtask

  task automatic check_codes(input string req);
    check(req, code_a, exp_code(1'b0));
    check(req, code_b, exp_code(1'b1));
  endtask

  task automatic do_load();
    load_strobe = 1'b1;
    tick(5);
    load_strobe = 1'b0;
    tick(4);
    m_dac[0] = m_in[0]; m_dac[1] = m_in[1];
  endtask

  task automatic model_clear(input logic [W-1:0] v);
    m_in[0] = v; m_in[1] = v; m_dac[0] = v; m_dac[1] = v;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear(16'h8000);
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1
    check_codes("R1");
    check("R1", bus_oe, 1'b0);
    check("R1", code_a_z, 16'h0000);
    check("R1", code_b_z, 16'h0000);
    do_read(1'b1, "R1");

    // R2 channel routing, outputs undisturbed
    do_write(1'b0, 16'h1234);
    check_codes("R2");
    do_write(1'b1, 16'hABCD);
    check_codes("R2");
    do_read(1'b0, "R3");
    do_read(1'b1, "R3");

    // R5 and R10 latency: change lands on third edge
    load_strobe = 1'b1;
    tick(2);
    check("R10", code_a, 16'h8000);
    tick(1);
    check("R10", code_a, 16'h1234);
    check("R5", code_b, 16'hABCD);
    load_strobe = 1'b0;
    tick(4);
    m_dac[0] = m_in[0]; m_dac[1] = m_in[1];
    check_codes("R5");

    // R6 load edge while chip select low
    do_write(1'b0, 16'h5555);
    rd_wr = 1'b1;
    cs_n = 1'b0;
    tick(4);
    load_strobe = 1'b1;
    tick(5);
    cs_n = 1'b1;
    tick(5);
    check_codes("R6");
    load_strobe = 1'b0;
    tick(4);
    check_codes("R6");

    // R7 held load level does not repeat
    do_load();
    check_codes("R5");
    load_strobe = 1'b1;
    tick(5);
    do_write(1'b1, 16'h0F0F);
    do_write(1'b0, 16'hF0F0);
    check_codes("R7");
    do_read(1'b1, "R7");
    load_strobe = 1'b0;
    tick(4);

    // R8 clear during a write in progress
    chan_sel = 1'b0; rd_wr = 1'b0; bus_in = 16'h7777;
    cs_n = 1'b0;
    tick(2);
    clr_strobe = 1'b1;
    tick(5);
    clr_strobe = 1'b0;
    tick(4);
    model_clear(16'h8000);
    check_codes("R8");
    check("R8", code_a_z, 16'h0000);
    check("R8", code_b_z, 16'h0000);
    rd_wr = 1'b1;
    tick(4);
    cs_n = 1'b1;
    tick(4);
    do_read(1'b0, "R8");
    do_read(1'b1, "R8");

    // R9 clear and load together
    do_write(1'b0, 16'h2468);
    do_write(1'b1, 16'h1357);
    load_strobe = 1'b1; clr_strobe = 1'b1;
    tick(5);
    load_strobe = 1'b0; clr_strobe = 1'b0;
    tick(4);
    model_clear(16'h8000);
    check_codes("R9");

    // random traffic
    for (int i = 0; i < 40; i++) begin
      int op;
      logic ch;
      op = int'($urandom % 3);
      ch = 1'($urandom);
      case (op)
        0: begin do_write(ch, W'($urandom)); check_codes("R2"); end
        1: do_read(ch, "R3");
        default: begin do_load(); check_codes("R5"); end
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule